// File: doc/BRIEF.md
# ARINC 429 Transmit Sequencer

This block holds a small queue of 32-bit words and sends them as a return-to-zero ARINC 429 stream on two digital lines, a high line and a low line. An external line driver takes these lines to the bus. Every bit time splits into a half with the data level and a half with null. After the last bit of each word the lines stay null for a fixed gap of four bit times. A 1 MHz reference tick, given as a one-cycle enable on the system clock, sets the timing. A select input picks the fast rate (10 ticks per bit) or the slow rate (80 ticks per bit). The rate is captured when each word starts.

Bit 32 of each word can be replaced with a computed parity bit. A burst of words starts in one of two ways. In automatic mode, the end of a load transaction starts the burst. In command mode, an explicit start pulse starts it. A burst ends once the queue is empty and the trailing gap of the last word is over. Words pushed before that point go out in the same burst. Words pushed after it wait for the next trigger.

An empty status output goes high only when the queue is empty and the sequencer has finished the last word and its gap. A driver-disable input forces both lines to null. A queue clear, or the asynchronous reset, aborts the current word at once.

Top module: `a429_tx_seq`

## Requirements
- R1: Line encoding: a one bit drives line_hi_o=1 and line_lo_o=0, a zero bit drives line_hi_o=0 and line_lo_o=1, and null drives both lines to 0. Both lines are never 1 together.
- R2: Bits go out in ARINC order. push_data_i[0] is sent first as ARINC bit 1, and push_data_i[31] (or the parity bit that replaces it) is sent last as bit 32.
- R3: With low_speed_i=0, each bit shows its data level for 5 ticks and then null for 5 ticks. Within a burst, the null from the end of bit 32's data level to the next word's first data level lasts 5+40 ticks.
- R4: With low_speed_i=1, the data level lasts 40 ticks, the null lasts 40 ticks, and the inter-word gap adds 320 ticks.
- R5: When parity_en_i=1, bit 32 is computed from bits 1 to 31: it makes the word's ones count odd when parity_even_i=0 and even when parity_even_i=1. When parity_en_i=0, all 32 pushed bits are sent unchanged.
- R6: With auto_start_i=1, a load_done_i pulse starts a burst. start_cmd_i has no effect in this mode, and pushed words are not sent until load_done_i.
- R7: With auto_start_i=0, a start_cmd_i pulse sends every queued word, including words pushed before the burst ends. Words pushed after the burst ends are held until the next start_cmd_i.
- R8: When the queue holds a word and the sequencer is idle, the first data level appears on the lines within two clock cycles of the trigger pulse.
- R9: drv_disable_i=1 forces both lines to null in the same cycle, whatever the sequencer state.
- R10: tx_empty_o is 1 after reset and goes 0 in the cycle after a push. It returns to 1 only once the queue is empty and the gap after the last word has fully elapsed, so it stays 0 while that gap runs.
- R11: clear_i empties the queue and aborts the word in flight. In the next cycle both lines are null and tx_empty_o is 1, and nothing further is sent.
- R12: The queue holds DEPTH words (4 by default), and full_o is 1 while it holds DEPTH words. A push while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse of the 1 MHz timing reference |
| low_speed_i | input | 1 | 1 selects the slow rate, 0 the fast rate |
| parity_en_i | input | 1 | Replace bit 32 with computed parity |
| parity_even_i | input | 1 | 0 odd parity, 1 even parity |
| auto_start_i | input | 1 | 1 automatic start mode, 0 command mode |
| drv_disable_i | input | 1 | Force both lines to null |
| push_i | input | 1 | Write push_data_i into the queue |
| push_data_i | input | 32 | Word to queue, bit 0 is ARINC bit 1 |
| load_done_i | input | 1 | End of a load transaction (automatic trigger) |
| start_cmd_i | input | 1 | Start command (command mode trigger) |
| clear_i | input | 1 | Clear the queue and abort transmission |
| full_o | output | 1 | Queue holds DEPTH words |
| tx_empty_o | output | 1 | Queue empty and last word fully sent |
| line_hi_o | output | 1 | Positive digital line |
| line_lo_o | output | 1 | Negative digital line |

## Verification
The assertions check the cycle-level invariants on every cycle. These are the exclusive line encoding, the null forced by the disable input, the quiet lines whenever the empty status is high, the empty status dropping after a push, and the immediate null and empty state after a clear. The bench scenarios cover what only a decoded stream can show. A line monitor measures every phase length in ticks at both rates and rebuilds the words bit by bit, so it can check the bit order and the computed parity over a sweep of patterns. It also checks that late pushes join a burst and that held words wait for a trigger. The scenarios also cover the trigger latency and dropping of pushes when the queue is full.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_MARK  = 2'd1,
    PH_SPACE = 2'd2,
    PH_GAP   = 2'd3
  } phase_e;
endpackage

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/a429_tx_fmt.sv
module a429_tx_fmt #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] word_i,
  input  logic             parity_en_i,
  input  logic             parity_even_i,
  output logic [WIDTH-1:0] word_o
);
  logic ones_odd;
  assign ones_odd = ^word_i[WIDTH-2:0];

  // last bit: even select -> copy ones parity, odd select -> its complement
  always_comb begin
    word_o = word_i;
    if (parity_en_i) word_o[WIDTH-1] = parity_even_i ? ones_odd : !ones_odd;
  end
endmodule

// File: rtl/a429_tx_engine.sv
module a429_tx_engine
  import a429_tx_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int HALF_HS  = 5,
  parameter int HALF_LS  = 40,
  parameter int GAP_BITS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             abort_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  input  logic             low_speed_i,
  output logic             busy_o,
  output logic             mark_o,
  output logic             bit_o
);
  localparam int GAP_HS  = 2 * HALF_HS * GAP_BITS;
  localparam int GAP_LS  = 2 * HALF_LS * GAP_BITS;
  localparam int GAP_MAX = (GAP_LS > GAP_HS) ? GAP_LS : GAP_HS;
  localparam int CNT_W   = $clog2(GAP_MAX + 1);
  localparam int IDX_W   = $clog2(WIDTH);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WIDTH - 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [WIDTH-1:0] sreg_q;
  logic             slow_q;
  logic [CNT_W-1:0] half_end, gap_end;

  assign half_end = slow_q ? CNT_W'(HALF_LS - 1) : CNT_W'(HALF_HS - 1);
  assign gap_end  = slow_q ? CNT_W'(GAP_LS - 1)  : CNT_W'(GAP_HS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sreg_q <= '0;
      slow_q <= 1'b0;
    end else if (abort_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else if (ph_q == PH_IDLE) begin
      if (load_i) begin
        ph_q   <= PH_MARK;
        cnt_q  <= '0;
        idx_q  <= '0;
        sreg_q <= word_i;
        slow_q <= low_speed_i;
      end
    end else if (tick_i) begin
      unique case (ph_q)
        PH_MARK: begin
          if (cnt_q == half_end) begin
            ph_q  <= PH_SPACE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_SPACE: begin
          if (cnt_q == half_end) begin
            cnt_q <= '0;
            if (idx_q == IDX_LAST) ph_q <= PH_GAP;
            else begin
              ph_q   <= PH_MARK;
              idx_q  <= idx_q + 1'b1;
              sreg_q <= sreg_q >> 1;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_GAP: begin
          if (cnt_q == gap_end) ph_q <= PH_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o = (ph_q != PH_IDLE);
  assign mark_o = (ph_q == PH_MARK);
  assign bit_o  = sreg_q[0];
endmodule

// File: rtl/a429_tx_seq.sv
module a429_tx_seq #(
  parameter int WIDTH    = 32,
  parameter int DEPTH    = 4,
  parameter int HALF_HS  = 5,
  parameter int HALF_LS  = 40,
  parameter int GAP_BITS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             low_speed_i,
  input  logic             parity_en_i,
  input  logic             parity_even_i,
  input  logic             auto_start_i,
  input  logic             drv_disable_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             load_done_i,
  input  logic             start_cmd_i,
  input  logic             clear_i,
  output logic             full_o,
  output logic             tx_empty_o,
  output logic             line_hi_o,
  output logic             line_lo_o
);
  logic [WIDTH-1:0] head, fmt_word;
  logic fifo_empty, pop, trigger, run_q;
  logic eng_busy, eng_mark, eng_bit;

  a429_tx_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clear_i),
    .push_i  (push_i),
    .data_i  (push_data_i),
    .pop_i   (pop),
    .data_o  (head),
    .empty_o (fifo_empty),
    .full_o  (full_o)
  );

  a429_tx_fmt #(.WIDTH(WIDTH)) u_fmt (
    .word_i        (head),
    .parity_en_i   (parity_en_i),
    .parity_even_i (parity_even_i),
    .word_o        (fmt_word)
  );

  a429_tx_engine #(
    .WIDTH(WIDTH), .HALF_HS(HALF_HS), .HALF_LS(HALF_LS), .GAP_BITS(GAP_BITS)
  ) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .abort_i     (clear_i),
    .load_i      (pop),
    .word_i      (fmt_word),
    .low_speed_i (low_speed_i),
    .busy_o      (eng_busy),
    .mark_o      (eng_mark),
    .bit_o       (eng_bit)
  );

  assign trigger = auto_start_i ? load_done_i : start_cmd_i;
  assign pop     = run_q && !eng_busy && !fifo_empty && !clear_i;

  // burst stays open until queue and engine drain together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      run_q <= 1'b0;
    else if (clear_i)                 run_q <= 1'b0;
    else if (trigger)                 run_q <= 1'b1;
    else if (!eng_busy && fifo_empty) run_q <= 1'b0;
  end

  assign tx_empty_o = fifo_empty && !eng_busy;
  assign line_hi_o  = !drv_disable_i && eng_mark && eng_bit;
  assign line_lo_o  = !drv_disable_i && eng_mark && !eng_bit;
endmodule

// File: rtl/a429_tx_seq_chk.sv
module a429_tx_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        low_speed_i,
  input logic        parity_en_i,
  input logic        parity_even_i,
  input logic        auto_start_i,
  input logic        drv_disable_i,
  input logic        push_i,
  input logic [31:0] push_data_i,
  input logic        load_done_i,
  input logic        start_cmd_i,
  input logic        clear_i,
  input logic        full_o,
  input logic        tx_empty_o,
  input logic        line_hi_o,
  input logic        line_lo_o
);
  AST_LINES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_hi_o && line_lo_o)); // R1
  AST_DISABLE_NULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_disable_i |-> (!line_hi_o && !line_lo_o)); // R9
  AST_EMPTY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> (!line_hi_o && !line_lo_o)); // R10
  AST_PUSH_DROPS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clear_i) |=> !tx_empty_o); // R10
  AST_CLEAR_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!line_hi_o && !line_lo_o && tx_empty_o)); // R11
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !tx_empty_o); // R12
endmodule

bind a429_tx_seq a429_tx_seq_chk chk_i (.*);

// File: tb/a429_tx_seq_tb.sv
module a429_tx_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int DEPTH      = 4;
  localparam int WD_CYCLES  = 190000;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic low_speed = 1'b0, par_en = 1'b0, par_even = 1'b0, auto_mode = 1'b0, drv_dis = 1'b0;
  logic push = 1'b0, load_done = 1'b0, start_cmd = 1'b0, clear = 1'b0;
  logic [31:0] push_data = '0;
  logic full, tx_empty, hi, lo;

  always #(CLK_PERIOD/2) clk = ~clk;

  a429_tx_seq #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .low_speed_i(low_speed),
    .parity_en_i(par_en), .parity_even_i(par_even), .auto_start_i(auto_mode),
    .drv_disable_i(drv_dis), .push_i(push), .push_data_i(push_data),
    .load_done_i(load_done), .start_cmd_i(start_cmd), .clear_i(clear),
    .full_o(full), .tx_empty_o(tx_empty), .line_hi_o(hi), .line_lo_o(lo)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // tick generator
  int tcnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin tcnt = 0; tick = 1'b0; end
    else begin
      tcnt = (tcnt == TDIV - 1) ? 0 : tcnt + 1;
      tick = (tcnt == TDIV - 1);
    end
  end

  // line monitor
  bit          mon_en = 1;
  int          prev_st = 0, seg_len = 0, bit_cnt = 0, cap_n = 0, last_gap = 0;
  int          h_ticks = 5;
  logic [31:0] cur_word = '0;
  logic [31:0] cap [64];

  function automatic bit near(input int len, input int ticks);
    return (len > (ticks - 1) * TDIV) && (len < (ticks + 1) * TDIV);
  endfunction

  always @(negedge clk) begin
    int st;
    if (rst_n && mon_en) begin
      st = hi ? 1 : (lo ? 2 : 0);
      if (st == prev_st) seg_len++;
      else begin
        if (prev_st != 0) begin
          chk(near(seg_len, h_ticks), low_speed ? "R4" : "R3", "data phase cycles",
              seg_len, h_ticks * TDIV);
          chk(st == 0, "R1", "data followed by null", st, 0);
          cur_word[bit_cnt] = (prev_st == 1);
          bit_cnt++;
          if (bit_cnt == 32) begin
            cap[cap_n] = cur_word;
            cap_n++;
            bit_cnt = 0;
          end
        end else if (bit_cnt > 0) begin
          chk(near(seg_len, h_ticks), low_speed ? "R4" : "R3", "null phase cycles",
              seg_len, h_ticks * TDIV);
        end else last_gap = seg_len;
        seg_len = 1;
        prev_st = st;
      end
    end
  end

  task automatic mon_reset();
    @(posedge clk);
    cap_n = 0; bit_cnt = 0; prev_st = 0; seg_len = 0; cur_word = '0; last_gap = 0;
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] d, input bit pe, input bit ev);
    logic [31:0] w = d;
    if (pe) w[31] = ev ? ^d[30:0] : ~^d[30:0];
    return w;
  endfunction

  task automatic push_word(input logic [31:0] d);
    @(negedge clk); push = 1'b1; push_data = d;
    @(negedge clk); push = 1'b0;
  endtask
  task automatic pulse_load();
    @(negedge clk); load_done = 1'b1; @(negedge clk); load_done = 1'b0;
  endtask
  task automatic pulse_start();
    @(negedge clk); start_cmd = 1'b1; @(negedge clk); start_cmd = 1'b0;
  endtask
  task automatic wait_idle(input int max);
    for (int i = 0; i < max && !tx_empty; i++) @(negedge clk);
  endtask
  task automatic wait_cap(input int n, input int max);
    for (int i = 0; i < max && cap_n < n; i++) @(negedge clk);
  endtask

  localparam logic [31:0] PATS [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h5555_5555,
                                       32'h2AAA_AAAA, 32'h8000_0001, 32'h1234_5678};

  initial begin
    int lat;
    bit quiet;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(!hi && !lo, "R1", "null after reset", {hi, lo}, 0);
    chk(tx_empty == 1'b1, "R10", "empty after reset", tx_empty, 1);
    chk(full == 1'b0, "R12", "not full after reset", full, 0);

    // command mode, fast, parity off
    push_word(32'h0000_0001);
    push_word(32'hC3A5_0F96);
    chk(tx_empty == 1'b0, "R10", "empty drops after push", tx_empty, 0);
    repeat (300) @(negedge clk);
    chk(cap_n == 0, "R7", "held without start", cap_n, 0);
    @(negedge clk); start_cmd = 1'b1;
    @(negedge clk); start_cmd = 1'b0;
    lat = 1;
    while (!(hi || lo) && lat < 20) begin @(negedge clk); lat++; end
    chk(lat <= 2, "R8", "first bit latency cycles", lat, 2);
    wait_cap(1, 3000);
    push_word(32'h8765_4321);
    wait_idle(8000);
    chk(cap_n == 3, "R7", "burst word count incl late push", cap_n, 3);
    chk(cap[0] == 32'h0000_0001, "R2", "bit 1 first", cap[0], 32'h1);
    chk(cap[1] == 32'hC3A5_0F96, "R2", "word order/bits", cap[1], 32'hC3A5_0F96);
    chk(cap[2] == 32'h8765_4321, "R7", "late word sent", cap[2], 32'h8765_4321);
    chk(near(last_gap, 45), "R3", "inter-word null cycles", last_gap, 45 * TDIV);
    push_word(32'h0F0F_0F0F);
    repeat (2000) @(negedge clk);
    chk(cap_n == 3, "R7", "post-burst word held", cap_n, 3);
    pulse_start();
    wait_idle(4000);
    chk(cap_n == 4 && cap[3] == 32'h0F0F_0F0F, "R7", "held word sent on start", cap[3], 32'h0F0F_0F0F);

    // automatic mode with parity sweep
    auto_mode = 1'b1;
    par_en = 1'b1;
    for (int ev = 0; ev < 2; ev++) begin
      par_even = ev[0];
      for (int p = 0; p < 6; p++) begin
        mon_reset();
        push_word(PATS[p]);
        if (ev == 0 && p == 0) begin
          pulse_start();
          repeat (200) @(negedge clk);
          chk(cap_n == 0 && !tx_empty, "R6", "start ignored in auto mode", cap_n, 0);
        end
        pulse_load();
        wait_cap(1, 3000);
        if (p == 5) chk(tx_empty == 1'b0, "R10", "empty low during trailing gap", tx_empty, 0);
        wait_idle(4000);
        chk(cap_n == 1 && cap[0] == exp_word(PATS[p], 1, ev[0]), "R5", "parity word",
            cap[0], exp_word(PATS[p], 1, ev[0]));
      end
    end
    par_en = 1'b0;
    mon_reset();
    push_word(32'h8000_0003);
    pulse_load();
    wait_idle(4000);
    chk(cap[0] == 32'h8000_0003, "R5", "parity off sends bit 32 as data", cap[0], 32'h8000_0003);
    chk(tx_empty == 1'b1, "R10", "empty after last word", tx_empty, 1);

    // low speed
    auto_mode = 1'b0;
    low_speed = 1'b1;
    h_ticks = 40;
    mon_reset();
    push_word(32'hA5A5_0001);
    push_word(32'h0000_F00D);
    pulse_start();
    wait_idle(30000);
    chk(cap_n == 2 && cap[1] == 32'h0000_F00D, "R4", "slow words", cap[1], 32'h0000_F00D);
    chk(near(last_gap, 360), "R4", "slow inter-word null cycles", last_gap, 360 * TDIV);
    low_speed = 1'b0;
    h_ticks = 5;

    // full queue
    mon_reset();
    for (int i = 0; i < DEPTH + 1; i++) begin
      push_word(32'h100 + i);
      if (i == DEPTH - 1) chk(full == 1'b1, "R12", "full at depth", full, 1);
    end
    pulse_start();
    wait_idle(10000);
    chk(cap_n == DEPTH, "R12", "extra push dropped", cap_n, DEPTH);
    chk(cap[DEPTH-1] == 32'h100 + DEPTH - 1, "R12", "last kept word", cap[DEPTH-1], 32'h100 + DEPTH - 1);

    // driver disable and clear
    mon_reset();
    push_word(32'hFFFF_FFFF);
    push_word(32'h0000_0000);
    pulse_start();
    repeat (60) @(negedge clk);
    mon_en = 0;
    drv_dis = 1'b1;
    quiet = 1;
    for (int i = 0; i < 80; i++) begin @(negedge clk); if (hi || lo) quiet = 0; end
    chk(quiet, "R9", "disable forces null", quiet, 1);
    drv_dis = 1'b0;
    for (int i = 0; i < 100 && !(hi || lo); i++) @(negedge clk);
    chk(hi || lo, "R9", "lines resume after disable", {hi, lo}, 2);
    clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    chk(!hi && !lo && tx_empty, "R11", "clear aborts at once", {hi, lo, tx_empty}, 1);
    quiet = 1;
    for (int i = 0; i < 600; i++) begin @(negedge clk); if (hi || lo) quiet = 0; end
    chk(quiet && tx_empty, "R11", "nothing sent after clear", quiet, 1);
    mon_reset();
    mon_en = 1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule